// File: doc/BRIEF.md
# Fetch Buffer with Branch-Miss Replay Queue

This block decouples an instruction fetch unit from an execution unit. Fetch pushes the words of the predicted path into a main FIFO, and execute pops them in program order. Each side can stall without holding the other, up to the depth of the queue. Every entry holds an instruction word and its program counter.

When fetch follows a predicted-taken branch, fetch has already read some sequential (fall-through) words during the two-cycle redirect bubble. Fetch marks these words, and the block parks them in a small side queue instead of discarding them. When the branch resolves as mispredicted, the main queue is flushed. The parked words then go to execute ahead of anything fetched afterwards, so they do not need to be fetched again. When the branch resolves as correctly predicted, the parked words are dropped. Only one branch can own the side queue at a time.

Top module: `fetch_miss_buffer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `x_valid` is 0, `f_ready` is 1 for a plain push, and both queues are empty.
- R2: The main queue holds MAIN_DEPTH entries (default 20) and issues them in push order. When it is full and no pop takes place in the same cycle, `f_ready` is 0 for a push with `f_fall`=0.
- R3: On a full main queue, a push and a pop in the same cycle are both accepted. The pushed word comes out after the words that were already queued.
- R4: A push with `f_taken`=1 and `f_fall`=0 is a predicted-taken branch. It enters the main queue and takes ownership of the side queue. While ownership is held, pushes with `f_fall`=1 go into the side queue. None of them is issued before the branch resolves. `f_fall`=1 takes precedence over `f_taken`.
- R5: A resolution (`r_valid`=1) with `r_mispredict`=1 while a branch owns the side queue does two things. It empties the main queue at the next clock edge. From the next cycle on, execute receives the side-queue words first, in fetch order, with `x_replay`=1. Words pushed after the resolution follow them, with `x_replay`=0.
- R6: A resolution with `r_mispredict`=0 clears the side queue without issuing any of its words. Issue continues from the main queue.
- R7: While a branch owns the side queue, or its words are still being replayed, `f_ready` is 0 for another predicted-taken branch.
- R8: When the side queue holds SIDE_DEPTH words (default 4), `f_ready` is 0 for a further push with `f_fall`=1 while ownership is held.
- R9: A resolution while no branch owns the side queue has no effect. A push with `f_fall`=1 while no branch owns the side queue is accepted and then discarded.
- R10: In the cycle in which a misprediction is signalled, `x_valid` is 0, so no wrong-path word is issued.
- R11: `x_pc` always shows the program counter that was pushed together with the word on `x_word`. This holds for replayed words as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_valid | input | 1 | Fetch offers a word |
| f_taken | input | 1 | Offered word is a predicted-taken branch |
| f_fall | input | 1 | Offered word is a fall-through word from the redirect bubble |
| f_word | input | IW | Instruction word |
| f_pc | input | AW | Program counter of the word |
| f_ready | output | 1 | Offered word is accepted this cycle |
| r_valid | input | 1 | Owning branch resolves this cycle |
| r_mispredict | input | 1 | Resolved branch was mispredicted |
| x_ready | input | 1 | Execute takes the presented word |
| x_valid | output | 1 | A word is presented to execute |
| x_word | output | IW | Presented instruction word |
| x_pc | output | AW | Presented program counter |
| x_replay | output | 1 | Presented word comes from the side queue |

## Verification
The embedded assertions check on every cycle the following properties:
- No queue ever holds more than its depth.
- A flush leaves a queue empty at the next edge.
- A full queue is never overwritten.
- The side queue never issues while a branch still owns it.
- A second taken branch is refused while ownership is held.
- No word is presented in a misprediction cycle.

Only the bench's scenarios can show the following:
- Program order across the two queues.
- Correct pairing of word and program counter.
- The fact that a correct prediction drops the parked words.

These scenarios sweep every fall-through count from zero to the side depth against both resolution outcomes.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
  parameter int unsigned FMB_IW = 32;
  parameter int unsigned FMB_AW = 32;

  typedef struct packed {
    logic [FMB_IW-1:0] word;
    logic [FMB_AW-1:0] pc;
  } fmb_entry_t;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_OWN    = 2'd1,
    S_REPLAY = 2'd2
  } fmb_state_e;
endpackage

// File: rtl/fmb_fifo.sv
module fmb_fifo
  import fmb_pkg::*;
#(
  parameter int unsigned DEPTH = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush_i,
  input  logic       push_i,
  input  fmb_entry_t din_i,
  input  logic       pop_i,
  output fmb_entry_t head_o,
  output logic       full_o,
  output logic       empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  fmb_entry_t mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic do_pop, do_push;

  assign do_pop  = pop_i && (count != '0);
  assign do_push = push_i && ((count != FULLC) || do_pop);

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push && !flush_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign full_o  = (count == FULLC);
  assign empty_o = (count == '0);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULLC);
  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full_o && push_i && !pop_i && !flush_i) |=> (full_o && $stable(wr_ptr)));
  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> empty_o);
endmodule

// File: rtl/fmb_ctrl.sv
module fmb_ctrl
  import fmb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic taken_acc_i,
  input  logic res_valid_i,
  input  logic res_mis_i,
  input  logic side_empty_i,
  output logic owned_o,
  output logic replay_o,
  output logic main_flush_o,
  output logic side_flush_o
);
  fmb_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:   if (taken_acc_i) state_nx = S_OWN;
      S_OWN:    if (res_valid_i)
                  state_nx = (res_mis_i && !side_empty_i) ? S_REPLAY : S_IDLE;
      S_REPLAY: if (side_empty_i) state_nx = S_IDLE;
      default:  state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= state_nx;
  end

  assign owned_o      = (state == S_OWN);
  assign replay_o     = (state == S_REPLAY);
  assign main_flush_o = owned_o && res_valid_i && res_mis_i;
  assign side_flush_o = owned_o && res_valid_i && !res_mis_i;

  // R7
  single_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({owned_o, replay_o}));
  // R4
  take_own_chk: assert property (@(posedge clk) disable iff (rst)
    taken_acc_i |=> owned_o);
  // R6
  good_release_chk: assert property (@(posedge clk) disable iff (rst)
    side_flush_o |=> (!owned_o && !replay_o));
endmodule

// File: rtl/fmb_issue.sv
module fmb_issue
  import fmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       replay_i,
  input  logic       hold_i,
  input  logic       side_empty_i,
  input  fmb_entry_t side_head_i,
  input  logic       main_empty_i,
  input  fmb_entry_t main_head_i,
  input  logic       x_ready_i,
  output logic       x_valid_o,
  output fmb_entry_t x_entry_o,
  output logic       x_side_o,
  output logic       pop_side_o,
  output logic       pop_main_o
);
  logic sel_side;

  assign sel_side  = replay_i && !side_empty_i;
  assign x_side_o  = sel_side;
  assign x_valid_o = !hold_i && (sel_side || !main_empty_i);
  assign x_entry_o = sel_side ? side_head_i : main_head_i;

  assign pop_side_o = x_valid_o && x_ready_i && sel_side;
  assign pop_main_o = x_valid_o && x_ready_i && !sel_side;

  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hold_i |-> (!pop_main_o && !pop_side_o));
  // R5
  side_first_chk: assert property (@(posedge clk) disable iff (rst)
    (replay_i && !side_empty_i) |-> !pop_main_o);
endmodule

// File: rtl/fetch_miss_buffer.sv
module fetch_miss_buffer
  import fmb_pkg::*;
#(
  parameter int unsigned MAIN_DEPTH = 20,
  parameter int unsigned SIDE_DEPTH = 4,
  parameter int unsigned IW = FMB_IW,
  parameter int unsigned AW = FMB_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          f_valid,
  input  logic          f_taken,
  input  logic          f_fall,
  input  logic [IW-1:0] f_word,
  input  logic [AW-1:0] f_pc,
  output logic          f_ready,
  input  logic          r_valid,
  input  logic          r_mispredict,
  input  logic          x_ready,
  output logic          x_valid,
  output logic [IW-1:0] x_word,
  output logic [AW-1:0] x_pc,
  output logic          x_replay
);
  fmb_entry_t in_ent, main_head, side_head, x_ent;
  logic main_full, main_empty, side_full, side_empty;
  logic owned, replay, main_flush, side_flush;
  logic pop_main, pop_side, push_main, push_side, taken_acc, main_room;

  assign in_ent.word = FMB_IW'(f_word);
  assign in_ent.pc   = FMB_AW'(f_pc);

  assign main_room = !main_full || pop_main;

  always_comb begin
    if (f_fall)       f_ready = owned ? !side_full : 1'b1;
    else if (f_taken) f_ready = !owned && !replay && main_room;
    else              f_ready = main_room;
  end

  assign push_main = f_valid && f_ready && !f_fall && !main_flush;
  assign push_side = f_valid && f_ready && f_fall && owned && !r_valid;
  assign taken_acc = f_valid && f_ready && f_taken && !f_fall;

  fmb_fifo #(.DEPTH(MAIN_DEPTH)) u_main (
    .clk(clk), .rst(rst), .flush_i(main_flush), .push_i(push_main),
    .din_i(in_ent), .pop_i(pop_main), .head_o(main_head),
    .full_o(main_full), .empty_o(main_empty)
  );

  fmb_fifo #(.DEPTH(SIDE_DEPTH)) u_side (
    .clk(clk), .rst(rst), .flush_i(side_flush), .push_i(push_side),
    .din_i(in_ent), .pop_i(pop_side), .head_o(side_head),
    .full_o(side_full), .empty_o(side_empty)
  );

  fmb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .taken_acc_i(taken_acc), .res_valid_i(r_valid),
    .res_mis_i(r_mispredict), .side_empty_i(side_empty), .owned_o(owned),
    .replay_o(replay), .main_flush_o(main_flush), .side_flush_o(side_flush)
  );

  fmb_issue u_issue (
    .clk(clk), .rst(rst), .replay_i(replay), .hold_i(main_flush),
    .side_empty_i(side_empty), .side_head_i(side_head),
    .main_empty_i(main_empty), .main_head_i(main_head),
    .x_ready_i(x_ready), .x_valid_o(x_valid), .x_entry_o(x_ent),
    .x_side_o(x_replay), .pop_side_o(pop_side), .pop_main_o(pop_main)
  );

  assign x_word = IW'(x_ent.word);
  assign x_pc   = AW'(x_ent.pc);

  // R4
  park_silent_chk: assert property (@(posedge clk) disable iff (rst)
    owned |-> !x_replay);
  // R7
  second_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (owned && f_taken && !f_fall) |-> !f_ready);
  // R10
  mispredict_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (owned && r_valid && r_mispredict) |-> !x_valid);
endmodule

// File: tb/test_fetch_miss_buffer.sv
module test_fetch_miss_buffer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic f_valid = 0, f_taken = 0, f_fall = 0, f_ready;
  logic [31:0] f_word = 0, f_pc = 0;
  logic r_valid = 0, r_mispredict = 0, x_ready = 0;
  logic x_valid, x_replay;
  logic [31:0] x_word, x_pc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fetch_miss_buffer i_fetch_miss_buffer (
    .clk(clk), .rst(rst), .f_valid(f_valid), .f_taken(f_taken), .f_fall(f_fall),
    .f_word(f_word), .f_pc(f_pc), .f_ready(f_ready), .r_valid(r_valid),
    .r_mispredict(r_mispredict), .x_ready(x_ready), .x_valid(x_valid),
    .x_word(x_word), .x_pc(x_pc), .x_replay(x_replay)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w, input logic tk, input logic fl,
                      input logic exp_rdy, input string req);
    @(negedge clk);
    f_valid = 1; f_word = w; f_pc = w << 2; f_taken = tk; f_fall = fl;
    #1 chk(f_ready == exp_rdy, req, f_ready, exp_rdy);
    @(posedge clk); #1;
    f_valid = 0; f_taken = 0; f_fall = 0;
  endtask

  task automatic pop(input logic [31:0] w, input logic rp, input string req);
    @(negedge clk);
    x_ready = 1;
    #1;
    chk(x_valid == 1'b1, req, x_valid, 1);
    chk(x_word == w, req, x_word, w);
    chk(x_pc == (w << 2), {req, "/R11"}, x_pc, w << 2);
    chk(x_replay == rp, req, x_replay, rp);
    @(posedge clk); #1;
    x_ready = 0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk); #1;
    chk(x_valid == 1'b0, req, x_valid, 0);
  endtask

  task automatic resolve(input logic mis);
    @(negedge clk);
    r_valid = 1; r_mispredict = mis;
    #1 if (mis) chk(x_valid == 1'b0, "R10", x_valid, 0);
    @(posedge clk); #1;
    r_valid = 0; r_mispredict = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk(x_valid == 1'b0, "R1", x_valid, 0);
    @(negedge clk) rst = 0;
    #1 chk(x_valid == 1'b0, "R1", x_valid, 0);
    chk(f_ready == 1'b1, "R1", f_ready, 1);

    // R2: fill to depth, then one more is refused
    for (int i = 0; i < 20; i++) push(32'h100 + i, 0, 0, 1, "R2");
    push(32'h1FF, 0, 0, 0, "R2");
    // R3: push and pop together on full
    @(negedge clk);
    f_valid = 1; f_word = 32'h200; f_pc = 32'h200 << 2; x_ready = 1;
    #1 chk(f_ready == 1'b1, "R3", f_ready, 1);
    chk(x_word == 32'h100, "R3", x_word, 32'h100);
    @(posedge clk); #1;
    f_valid = 0; x_ready = 0;
    for (int i = 1; i < 20; i++) pop(32'h100 + i, 0, "R2");
    pop(32'h200, 0, "R3");
    expect_empty("R2");

    // R4..R8: sweep fall-through count and outcome
    for (int k = 0; k <= 4; k++) begin
      for (int m = 0; m < 2; m++) begin
        logic [31:0] base;
        base = 32'h1000 * (k * 2 + m + 1);
        push(base, 1, 0, 1, "R4");
        push(base + 32'hF, 1, 0, 0, "R7");
        for (int i = 0; i < k; i++) push(base + 32'h10 + i, 0, 1, 1, "R4");
        if (k == 4) push(base + 32'h1F, 0, 1, 0, "R8");
        for (int i = 0; i < 3; i++) push(base + 32'h20 + i, 0, 0, 1, "R4");
        pop(base, 0, "R4");
        pop(base + 32'h20, 0, "R4");
        resolve(m[0]);
        if (m == 1 && k > 0) push(base + 32'hE, 1, 0, 0, "R7");
        for (int i = 0; i < 2; i++) push(base + 32'h30 + i, 0, 0, 1, "R5");
        if (m == 1) begin
          for (int i = 0; i < k; i++) pop(base + 32'h10 + i, 1, "R5");
        end else begin
          for (int i = 1; i < 3; i++) pop(base + 32'h20 + i, 0, "R6");
        end
        for (int i = 0; i < 2; i++) pop(base + 32'h30 + i, 0, m ? "R5" : "R6");
        expect_empty(m ? "R5" : "R6");
      end
    end

    // R9: stray resolution and stray fall-through word
    resolve(1'b0);
    resolve(1'b1);
    push(32'h9000, 0, 1, 1, "R9");
    push(32'h9001, 0, 0, 1, "R9");
    pop(32'h9001, 0, "R9");
    expect_empty("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule